// File: doc/BRIEF.md
# Phase-Offset Half-Duty Clock Divider

This block divides a carrier clock by a programmable even integer. It produces an output that is high for exactly half of each period. The output's edges can be moved away from the counter's zero point by a programmable phase value. The design runs on one system clock. The carrier appears as a one-cycle enable pulse, and the internal counter advances only on cycles where that pulse is high.

The counter runs from zero up to divisor−1 and then wraps. On the step where the count reaches 1 + phase, the output rises. On the step where the count reaches 1 + divisor/2 + phase, the output falls. The two compare points always move together, so the duty cycle stays at 50% for any legal phase. The wrap point is fixed by the divisor alone. A synchronous restart input sends the counter back to zero at any time.

Divisor and phase are captured only at a wrap or a restart, so a setting changed mid-period takes effect cleanly. An illegal setting raises a flag and keeps the output low.

Top module: `phase_clkdiv`

## Requirements
- R1: While and after a synchronous active-high reset, `clk_out` and `cfg_err` are 0, the counter is zero, and the captured divisor and phase are zero.
- R2: With a legal captured divisor D, the counter takes the values 0 to D−1 on successive carrier ticks. `clk_out` is periodic with period D ticks.
- R3: With a legal setting, `clk_out` stays high for exactly D/2 ticks and low for exactly D/2 ticks in each period.
- R4: Counting ticks from the zero point, `clk_out` rises on the tick where the count becomes 1 + P. It falls on the tick where the count becomes 1 + D/2 + P. Whenever the count becomes zero, `clk_out` is driven low.
- R5: When `restart` is high at a clock edge, it takes priority over the tick. The counter goes to zero, `clk_out` goes low, and `div_in`/`phase_in` are captured.
- R6: On clock edges where both `carrier_tick` and `restart` are low, the count does not move and `clk_out` keeps its value.
- R7: `div_in` and `phase_in` are captured only at a wrap (the tick where count+1 reaches the captured divisor) or at a restart. Changes at other times have no effect on `clk_out`.
- R8: A captured setting is legal when D is even, D ≥ 2, and 1 + D/2 + P < D. When an illegal setting is captured, `cfg_err` goes high and `clk_out` stays low until a legal setting is captured. When a legal setting is captured, `cfg_err` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| carrier_tick | input | 1 | One-cycle enable pulse for each carrier clock period |
| restart | input | 1 | Synchronous counter restart and setting capture |
| div_in | input | CNT_W | Divisor request |
| phase_in | input | CNT_W | Phase offset request, in ticks |
| clk_out | output | 1 | Divided half-duty output |
| cfg_err | output | 1 | Captured setting is illegal |

## Verification
The embedded properties assume three things. First, a nonzero captured divisor always bounds the counter. Second, the output only rises at the captured set point. Third, it only falls at the captured clear point or at zero. These assumptions rely on the divisor changing only at a capture, which the block enforces itself. The stimulus draws divisors and phases from ranges that include many illegal values, such as phase past the half period, and pairs them with sparse carrier ticks and rare restarts. This means both error and normal regimes are exercised. Every request stays within `CNT_W` bits, so compare-point arithmetic never wraps.

// File: rtl/phdiv_pkg.sv
package phdiv_pkg;

   // action taken on the output register at a counter step
   typedef enum logic [1:0] {
      EDGE_HOLD = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_DROP = 2'd2
   } edge_act_t;

endpackage

// File: rtl/phdiv_count.sv
module phdiv_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             restart,
   input  logic [CNT_W-1:0] div_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             step,
   output logic             capture
);

   logic [CNT_W:0] inc;
   logic           wrap;

   assign inc     = {1'b0, cnt_q} + 1'b1;
   assign wrap    = tick && (inc >= {1'b0, div_q});
   assign step    = tick || restart;
   assign capture = restart || wrap;

   always_comb begin
      if (restart || wrap)
         cnt_nxt = '0;
      else if (tick)
         cnt_nxt = inc[CNT_W-1:0];
      else
         cnt_nxt = cnt_q;
   end

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_nxt;
   end

   // R2: count never reaches a nonzero captured divisor
   a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
      (div_q != '0) |-> (cnt_q < div_q));

   // R5: restart zeroes the count
   a_r5_restart_zero: assert property (@(posedge clk) disable iff (rst)
      restart |=> (cnt_q == '0));

   // R6: idle edges leave the count alone
   a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
      (!tick && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/phdiv_cfg.sv
module phdiv_cfg #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             capture,
   input  logic [CNT_W-1:0] div_in,
   input  logic [CNT_W-1:0] phase_in,
   output logic [CNT_W-1:0] div_q,
   output logic [CNT_W-1:0] ph_q,
   output logic [CNT_W:0]   set_pt,
   output logic [CNT_W:0]   clr_pt,
   output logic             cfg_ok,
   output logic             err_q
);

   localparam int EXT_W = CNT_W + 1;

   logic [EXT_W-1:0] half_q;
   logic [EXT_W-1:0] req_clr;
   logic             req_ok;

   function automatic logic legal(input logic [CNT_W-1:0] d,
                                  input logic [CNT_W-1:0] p);
      logic [EXT_W:0] edge_hi;
      edge_hi = {2'b00, p} + {3'b000, d[CNT_W-1:1]} + 1'b1;
      return (d[0] == 1'b0) && (d >= 2) && (edge_hi < {2'b00, d});
   endfunction

   assign req_ok  = legal(div_in, phase_in);
   assign half_q  = {2'b00, div_q[CNT_W-1:1]};
   assign set_pt  = {1'b0, ph_q} + 1'b1;
   assign req_clr = set_pt + half_q;
   assign clr_pt  = req_clr;
   assign cfg_ok  = legal(div_q, ph_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         div_q <= '0;
         ph_q  <= '0;
         err_q <= 1'b0;
      end else if (capture) begin
         div_q <= div_in;
         ph_q  <= phase_in;
         err_q <= !req_ok;
      end
   end

   // R7: setting only moves at a capture
   a_r7_cfg_hold: assert property (@(posedge clk) disable iff (rst)
      !capture |=> ($stable(div_q) && $stable(ph_q)));

   // R8: flag tracks legality of what was captured
   a_r8_err_match: assert property (@(posedge clk) disable iff (rst)
      capture |=> (err_q == !cfg_ok));

endmodule

// File: rtl/phdiv_edge.sv
module phdiv_edge
   import phdiv_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   input  logic [CNT_W-1:0] cnt_q,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic [CNT_W:0]   set_pt,
   input  logic [CNT_W:0]   clr_pt,
   input  logic             cfg_ok,
   input  logic             err_q,
   output logic             out_q
);

   edge_act_t act;
   logic      out_d;

   always_comb begin
      act = EDGE_HOLD;
      if (step) begin
         if (cnt_nxt == '0)                    act = EDGE_DROP;
         else if ({1'b0, cnt_nxt} == set_pt)   act = EDGE_RISE;
         else if ({1'b0, cnt_nxt} == clr_pt)   act = EDGE_DROP;
      end
   end

   always_comb begin
      if (!cfg_ok) out_d = 1'b0;
      else begin
         unique case (act)
            EDGE_RISE: out_d = 1'b1;
            EDGE_DROP: out_d = 1'b0;
            default:   out_d = out_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) out_q <= 1'b0;
      else     out_q <= out_d;
   end

   // R4: rise only at the captured set point
   a_r4_rise_at_set: assert property (@(posedge clk) disable iff (rst)
      $rose(out_q) |-> ({1'b0, cnt_q} == set_pt));

   // R4: fall only at the clear point or at zero
   a_r4_fall_at_clr: assert property (@(posedge clk) disable iff (rst)
      $fell(out_q) |-> (({1'b0, cnt_q} == clr_pt) || (cnt_q == '0)));

   // R8: flagged setting keeps output low
   a_r8_err_low: assert property (@(posedge clk) disable iff (rst)
      err_q |-> !out_q);

endmodule

// File: rtl/phase_clkdiv.sv
module phase_clkdiv #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             carrier_tick,
   input  logic             restart,
   input  logic [CNT_W-1:0] div_in,
   input  logic [CNT_W-1:0] phase_in,
   output logic             clk_out,
   output logic             cfg_err
);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("phase_clkdiv: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic [CNT_W-1:0] div_q;
   logic [CNT_W-1:0] ph_q;
   logic [CNT_W:0]   set_pt;
   logic [CNT_W:0]   clr_pt;
   logic             step;
   logic             capture;
   logic             cfg_ok;
   logic             err_q;

   phdiv_count #(.CNT_W(CNT_W)) u_count (
      .clk     (clk),
      .rst     (rst),
      .tick    (carrier_tick),
      .restart (restart),
      .div_q   (div_q),
      .cnt_q   (cnt_q),
      .cnt_nxt (cnt_nxt),
      .step    (step),
      .capture (capture)
   );

   phdiv_cfg #(.CNT_W(CNT_W)) u_cfg (
      .clk      (clk),
      .rst      (rst),
      .capture  (capture),
      .div_in   (div_in),
      .phase_in (phase_in),
      .div_q    (div_q),
      .ph_q     (ph_q),
      .set_pt   (set_pt),
      .clr_pt   (clr_pt),
      .cfg_ok   (cfg_ok),
      .err_q    (err_q)
   );

   phdiv_edge #(.CNT_W(CNT_W)) u_edge (
      .clk     (clk),
      .rst     (rst),
      .step    (step),
      .cnt_q   (cnt_q),
      .cnt_nxt (cnt_nxt),
      .set_pt  (set_pt),
      .clr_pt  (clr_pt),
      .cfg_ok  (cfg_ok),
      .err_q   (err_q),
      .out_q   (clk_out)
   );

   assign cfg_err = err_q;

   // R1: reset leaves output and flag low
   a_r1_reset_low: assert property (@(posedge clk)
      rst |=> (!clk_out && !cfg_err));

   // R5: restart forces output low
   a_r5_restart_low: assert property (@(posedge clk) disable iff (rst)
      restart |=> !clk_out);

endmodule

// File: tb/phase_clkdiv_bench.sv
module phase_clkdiv_bench;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         tick = 1'b0;
   logic         rs = 1'b0;
   logic [W-1:0] din = '0;
   logic [W-1:0] pin = '0;
   logic         clk_out;
   logic         cfg_err;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   // reference state
   int  m_cnt = 0, m_div = 0, m_ph = 0;
   bit  m_out = 0, m_err = 0;

   always #10 clk = ~clk;

   phase_clkdiv #(.CNT_W(W)) u_phase_clkdiv (
      .clk(clk), .rst(rst), .carrier_tick(tick), .restart(rs),
      .div_in(din), .phase_in(pin), .clk_out(clk_out), .cfg_err(cfg_err));

   function automatic bit good(int d, int p);
      return (d % 2 == 0) && (d >= 2) && (1 + d / 2 + p < d);
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_cnt = 0; m_div = 0; m_ph = 0; m_out = 0; m_err = 0;
      end else if (rs) begin
         m_cnt = 0; m_div = din; m_ph = pin; m_out = 0; m_err = !good(din, pin);
      end else if (tick) begin
         if (m_cnt + 1 >= m_div) begin
            m_cnt = 0; m_div = din; m_ph = pin; m_out = 0; m_err = !good(din, pin);
         end else begin
            m_cnt = m_cnt + 1;
            if (!good(m_div, m_ph)) m_out = 0;
            else if (m_cnt == 1 + m_ph) m_out = 1;
            else if (m_cnt == 1 + m_div / 2 + m_ph) m_out = 0;
         end
      end else if (!good(m_div, m_ph)) m_out = 0;
   end

   task automatic cmp(string tag);
      n_cmp++;
      if (clk_out !== m_out) begin
         n_bad++;
         $display("FAIL %s clk_out actual=%0b expected=%0b", tag, clk_out, m_out);
      end
      n_cmp++;
      if (cfg_err !== m_err) begin
         n_bad++;
         $display("FAIL %s cfg_err actual=%0b expected=%0b", tag, cfg_err, m_err);
      end
   endtask

   task automatic cyc(string tag);
      @(posedge clk);
      @(negedge clk);
      cmp(tag);
   endtask

   task automatic do_restart(int d, int p);
      din = d[W-1:0]; pin = p[W-1:0]; rs = 1; tick = 0;
      cyc("R5");
      rs = 0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'h1234_5EED));
      @(negedge clk);
      cyc("R1");
      cyc("R1");
      rst = 0;
      cyc("R1");

      // R4: D=8 P=1, rise on count 2, fall on count 6
      do_restart(8, 1);
      tick = 1;
      for (int i = 0; i < 24; i++) cyc("R4");

      // R3: 50% duty, D=12 P=0, count high ticks explicitly
      do_restart(12, 0);
      tick = 1;
      begin
         int hi = 0;
         for (int i = 0; i < 12; i++) begin
            cyc("R3");
            if (clk_out) hi++;
         end
         n_cmp++;
         if (hi != 6) begin
            n_bad++;
            $display("FAIL R3 high ticks actual=%0d expected=6", hi);
         end
      end

      // R2: period check D=10 P=3, output repeats every 10 ticks
      do_restart(10, 3);
      tick = 1;
      begin
         bit hist[30];
         for (int i = 0; i < 30; i++) begin
            cyc("R2");
            hist[i] = clk_out;
         end
         for (int i = 10; i < 30; i++) begin
            n_cmp++;
            if (hist[i] != hist[i-10]) begin
               n_bad++;
               $display("FAIL R2 tick %0d actual=%0b expected=%0b", i, hist[i], hist[i-10]);
            end
         end
      end

      // R6: no tick holds the output
      do_restart(8, 0);
      tick = 1;
      cyc("R6"); cyc("R6"); cyc("R6");
      tick = 0;
      for (int i = 0; i < 5; i++) cyc("R6");

      // R7: request change mid-period is ignored until wrap
      do_restart(8, 0);
      tick = 1;
      cyc("R7");
      din = 8'd3; pin = 8'd7;
      for (int i = 0; i < 6; i++) cyc("R7");
      din = 8'd8; pin = 8'd1;
      for (int i = 0; i < 10; i++) cyc("R7");

      // R8: illegal settings (odd, too small, phase too large), then recovery
      do_restart(7, 0);  tick = 1; for (int i = 0; i < 10; i++) cyc("R8");
      do_restart(2, 0);  for (int i = 0; i < 6; i++) cyc("R8");
      do_restart(8, 3);  for (int i = 0; i < 10; i++) cyc("R8");
      do_restart(8, 2);  for (int i = 0; i < 10; i++) cyc("R8");

      // random mix
      for (int i = 0; i < 4000; i++) begin
         tick = ($urandom_range(0, 9) < 7);
         rs   = ($urandom_range(0, 99) == 0);
         if ($urandom_range(0, 19) == 0) begin
            int d;
            d = 2 * $urandom_range(1, 20);
            if ($urandom_range(0, 7) == 0) d = d + 1;
            din = d[W-1:0];
            pin = W'($urandom_range(0, d));
         end
         cyc("R2");
      end

      // R1: reset mid-run
      rst = 1;
      cyc("R1");
      rst = 0;
      tick = 0;
      cyc("R1");

      finish_run();
   end

endmodule